// File: doc/BRIEF.md
# Full-Duplex SPI Master with Slave-Select Fault Monitor

This block is the serial side of a 24-bit processor peripheral that talks to SPI slaves as the bus master. Software sets the divider, clock polarity and clock phase, then turns the block on. It starts a transfer by writing a word into the transmit holding register. The word moves into a shift register and the block produces 48 serial-clock edges. Data leaves on MOSI, most significant bit first, and MISO is sampled on the other edge of each bit. The received word goes into a two-entry receive queue, and software reads it back from there.

The block serves only as master. Its own slave-select pin is an input that normal operation holds high. Any low level seen on that pin while the block is active means another master is driving the bus, so a sticky bus-error flag is set. Status flags report that the holding register is empty, that the receive queue holds data, and that a received word was lost. Each flag can raise the interrupt line when its enable bit is set. Removing any of the three activation conditions works as a local reset.

Top module: `spi_fault_master`

## Requirements
- R1: The block is active only while cfg_enable=1, cfg_mode_sel=0 and cfg_master=1. While it is inactive, tx_wr is ignored, stat_tx_empty stays 1, sck rests at cfg_cpol, stat_berr stays 0 and irq is 0.
- R2: A tx_wr that arrives while stat_tx_empty=1 captures tx_data into the holding register. A tx_wr that arrives while stat_tx_empty=0 is dropped and leaves no trace in the received data.
- R3: sck toggles once every cfg_div+1 clock cycles while a word is moving. The first toggle comes cfg_div+1 cycles after the load, each word takes exactly 48 toggles, and between words sck rests at cfg_cpol.
- R4: Words are shifted MSB first, and MOSI shows the MSB from the load cycle onward. With cfg_cpha=0, MISO is sampled on toggles 1,3,5,… and MOSI advances on toggles 2,4,…. With cfg_cpha=1, MISO is sampled on toggles 2,4,…,48 and MOSI advances on toggles 3,5,…,47.
- R5: stat_tx_empty returns to 1 on the clock after the holding register is copied into the shift register. A word already waiting is loaded in the same cycle as the last toggle of the previous word, so no idle cycle separates the two.
- R6: Each finished word is appended to the receive queue. stat_rx_nempty=1 while the queue holds a word, rx_data shows the oldest word, and rx_rd removes that word.
- R7: The queue holds 2 words. A word that finishes while the queue is full and no rx_rd arrives in the same cycle is dropped, and it sets the sticky flag stat_rx_ovr.
- R8: While the block is active, ss_n=0 sets the sticky flag stat_berr two clocks later (after a two-stage synchronizer). Any transfer in progress keeps running.
- R9: irq = active AND ((stat_berr AND cfg_berr_ie) OR (stat_tx_empty AND cfg_txe_ie) OR (stat_rx_nempty AND cfg_rxne_ie)).
- R10: When the block leaves the active state, any transfer in progress stops, the holding register and receive queue are emptied, and stat_rx_ovr and stat_berr are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Interface enable; 0 works as a local reset |
| cfg_mode_sel | input | 1 | Protocol select; 0 selects SPI |
| cfg_master | input | 1 | Master select; must be 1 |
| cfg_cpol | input | 1 | Level at which sck rests |
| cfg_cpha | input | 1 | Chooses whether MISO is sampled on the first or the second edge of each bit |
| cfg_div | input | 8 | Divider N; sck runs at f/(2(N+1)) |
| cfg_berr_ie | input | 1 | Interrupt enable for the bus-error flag |
| cfg_txe_ie | input | 1 | Interrupt enable for transmit-empty |
| cfg_rxne_ie | input | 1 | Interrupt enable for receive-not-empty |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_data | input | 24 | Word to send |
| rx_rd | input | 1 | Removes the oldest received word |
| rx_data | output | 24 | Oldest received word |
| stat_tx_empty | output | 1 | Holding register can accept a word |
| stat_rx_nempty | output | 1 | Receive queue holds at least one word |
| stat_rx_ovr | output | 1 | Sticky flag: a received word was lost |
| stat_berr | output | 1 | Sticky flag: slave-select was seen low |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Slave-select input, watched for faults |

## Verification
MISO is driven four ways, and each exposes a different class of fault. A loopback from MOSI means a correct edge choice must return the transmitted word, and this is tried in both phase settings. Constant ones tell a full-word capture apart from a truncated one. A fresh pseudo-random bit every clock catches any sampling that lands one cycle early or late. Back-to-back queued writes, an extra write while the register is full, three words with no read, a disable in the middle of a word, and pulses on slave-select with the block active and inactive cover the reload, drop, overrun, flush and fault paths.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int SPIM_WORD_W = 24;
    localparam int SPIM_DIV_W  = 8;

    typedef struct packed {
        logic                  enable;
        logic                  mode_sel;
        logic                  master;
        logic                  cpol;
        logic                  cpha;
        logic [SPIM_DIV_W-1:0] div;
    } spim_cfg_t;

    typedef enum logic {
        XFER_IDLE = 1'b0,
        XFER_RUN  = 1'b1
    } xfer_state_e;

    function automatic logic spim_is_active(input spim_cfg_t c);
        return c.enable && !c.mode_sel && c.master;
    endfunction

endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen
    import spim_pkg::*;
#(
    parameter int WORD_W = SPIM_WORD_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        start,
    input  logic                        run,
    input  logic [SPIM_DIV_W-1:0]       div,
    output logic                        tick,
    output logic                        last,
    output logic                        phase,
    output logic [$clog2(2*WORD_W)-1:0] ecnt
);
    localparam int EDGES = 2 * WORD_W;
    localparam int EW    = $clog2(EDGES);

    logic [SPIM_DIV_W-1:0] cnt;

    assign tick = run && (cnt >= div);
    assign last = tick && (ecnt == EW'(EDGES - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || start) begin
            cnt   <= '0;
            ecnt  <= '0;
            phase <= 1'b0;
        end else if (run) begin
            if (tick) begin
                cnt   <= '0;
                phase <= ~phase;
                ecnt  <= last ? '0 : ecnt + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !start && !clr) |=> $stable(phase));

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int WORD_W = SPIM_WORD_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        load,
    input  logic [WORD_W-1:0]           load_data,
    input  logic                        tick,
    input  logic [$clog2(2*WORD_W)-1:0] ecnt,
    input  logic                        cpha,
    input  logic                        miso,
    output logic                        mosi,
    output logic [WORD_W-1:0]           done_word
);
    logic [WORD_W-1:0] txs;
    logic [WORD_W-1:0] rxs;
    logic              sample_now;
    logic              shift_now;

    assign sample_now = tick && (ecnt[0] == cpha);
    assign shift_now  = tick && !sample_now && (ecnt != '0);
    assign mosi       = txs[WORD_W-1];
    assign done_word  = sample_now ? {rxs[WORD_W-2:0], miso} : rxs;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            txs <= '0;
            rxs <= '0;
        end else if (load) begin
            txs <= load_data;
        end else begin
            if (sample_now) rxs <= {rxs[WORD_W-2:0], miso};
            if (shift_now)  txs <= {txs[WORD_W-2:0], 1'b0};
        end
    end

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift_now && !clr) |=> $stable(mosi));

endmodule

// File: rtl/spim_rxfifo.sv
module spim_rxfifo #(
    parameter int W     = 24,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_p;
    logic [AW-1:0] wr_p;
    logic [CW-1:0] cnt;
    logic          do_pop;
    logic          do_push;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_p];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_p] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_p <= '0;
            wr_p <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wr_p <= step(wr_p);
            if (do_pop)  rd_p <= step(rd_p);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/spi_fault_master.sv
module spi_fault_master
    import spim_pkg::*;
#(
    parameter int WORD_W     = SPIM_WORD_W,
    parameter int FIFO_DEPTH = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_enable,
    input  logic                  cfg_mode_sel,
    input  logic                  cfg_master,
    input  logic                  cfg_cpol,
    input  logic                  cfg_cpha,
    input  logic [SPIM_DIV_W-1:0] cfg_div,
    input  logic                  cfg_berr_ie,
    input  logic                  cfg_txe_ie,
    input  logic                  cfg_rxne_ie,
    input  logic                  tx_wr,
    input  logic [WORD_W-1:0]     tx_data,
    input  logic                  rx_rd,
    output logic [WORD_W-1:0]     rx_data,
    output logic                  stat_tx_empty,
    output logic                  stat_rx_nempty,
    output logic                  stat_rx_ovr,
    output logic                  stat_berr,
    output logic                  irq,
    output logic                  sck,
    output logic                  mosi,
    input  logic                  miso,
    input  logic                  ss_n
);
    localparam int EW = $clog2(2 * WORD_W);

    spim_cfg_t   cfg;
    logic        active;
    xfer_state_e state;
    logic        hold_v;
    logic [WORD_W-1:0] hold_q;
    logic        load;
    logic        tick;
    logic        last;
    logic        sck_phase;
    logic [EW-1:0] ecnt;
    logic [WORD_W-1:0] done_word;
    logic        q_empty;
    logic        q_full;
    logic        pop_req;
    logic        ss_s1;
    logic        ss_s2;

    assign cfg = '{enable: cfg_enable, mode_sel: cfg_mode_sel, master: cfg_master,
                   cpol: cfg_cpol, cpha: cfg_cpha, div: cfg_div};
    assign active  = spim_is_active(cfg);
    assign load    = active && hold_v && ((state == XFER_IDLE) || last);
    assign pop_req = active && rx_rd;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            hold_v <= 1'b0;
            hold_q <= '0;
        end else if (load) begin
            hold_v <= 1'b0;
        end else if (tx_wr && !hold_v) begin
            hold_v <= 1'b1;
            hold_q <= tx_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active)  state <= XFER_IDLE;
        else if (load)       state <= XFER_RUN;
        else if (last)       state <= XFER_IDLE;
    end

    spim_clkgen #(.WORD_W(WORD_W)) u_clkgen (
        .clk   (clk),
        .rst   (rst),
        .clr   (!active),
        .start (load),
        .run   (state == XFER_RUN),
        .div   (cfg.div),
        .tick  (tick),
        .last  (last),
        .phase (sck_phase),
        .ecnt  (ecnt)
    );

    spim_shifter #(.WORD_W(WORD_W)) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .clr       (!active),
        .load      (load),
        .load_data (hold_q),
        .tick      (tick),
        .ecnt      (ecnt),
        .cpha      (cfg.cpha),
        .miso      (miso),
        .mosi      (mosi),
        .done_word (done_word)
    );

    spim_rxfifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxfifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (!active),
        .push  (last),
        .pop   (pop_req),
        .din   (done_word),
        .dout  (rx_data),
        .empty (q_empty),
        .full  (q_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ss_s1 <= 1'b1;
            ss_s2 <= 1'b1;
        end else begin
            ss_s1 <= ss_n;
            ss_s2 <= ss_s1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            stat_berr   <= 1'b0;
            stat_rx_ovr <= 1'b0;
        end else begin
            if (!ss_s2) stat_berr <= 1'b1;
            if (last && q_full && !pop_req) stat_rx_ovr <= 1'b1;
        end
    end

    assign stat_tx_empty  = !hold_v;
    assign stat_rx_nempty = !q_empty;
    assign sck            = cfg.cpol ^ sck_phase;
    assign irq            = active && ((stat_berr && cfg_berr_ie) ||
                                       (stat_tx_empty && cfg_txe_ie) ||
                                       (stat_rx_nempty && cfg_rxne_ie));

    // R5
    txe_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> stat_tx_empty);

    // R2
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (active && tx_wr && !stat_tx_empty && !load) |=> $stable(hold_q));

    // R8
    berr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !ss_s2) |=> stat_berr);

    // R10
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> (!stat_rx_nempty && !stat_rx_ovr && !stat_berr && stat_tx_empty));

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (state == XFER_IDLE) |-> (sck == cfg_cpol));

endmodule

// File: tb/spi_fault_master_bench.sv
module spi_fault_master_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 0, cfg_mode_sel = 0, cfg_master = 0;
    logic        cfg_cpol = 0, cfg_cpha = 0;
    logic [7:0]  cfg_div = 0;
    logic        cfg_berr_ie = 0, cfg_txe_ie = 0, cfg_rxne_ie = 0;
    logic        tx_wr = 0;
    logic [23:0] tx_data = 0;
    logic        rx_rd = 0;
    logic [23:0] rx_data;
    logic        stat_tx_empty, stat_rx_nempty, stat_rx_ovr, stat_berr, irq;
    logic        sck, mosi;
    logic        miso = 0;
    logic        ss_n = 1;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    int miso_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    spi_fault_master u_spi_fault_master (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_mode_sel(cfg_mode_sel),
        .cfg_master(cfg_master), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_div(cfg_div), .cfg_berr_ie(cfg_berr_ie), .cfg_txe_ie(cfg_txe_ie),
        .cfg_rxne_ie(cfg_rxne_ie), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
        .rx_data(rx_data), .stat_tx_empty(stat_tx_empty), .stat_rx_nempty(stat_rx_nempty),
        .stat_rx_ovr(stat_rx_ovr), .stat_berr(stat_berr), .irq(irq), .sck(sck),
        .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    // ---------------- behavioural reference ----------------
    bit          m_busy = 0, m_hold_v = 0, m_ovr = 0, m_berr = 0;
    bit          m_ss1 = 1, m_ss2 = 1;
    logic [23:0] m_hold = 0, m_tx = 0, m_rx = 0;
    int          m_since = 0, m_edges = 0, m_shifts = 0;
    logic [23:0] m_q[$];

    always @(posedge clk) begin
        bit act, ss_old, busy_old, hv_old, tk, fin, smp;
        int e;
        act    = cfg_enable && !cfg_mode_sel && cfg_master;
        ss_old = m_ss2;
        m_ss2  = m_ss1;
        m_ss1  = ss_n;
        if (rst || !act) begin
            if (rst) begin m_ss1 = 1; m_ss2 = 1; end
            m_busy = 0; m_hold_v = 0; m_ovr = 0; m_berr = 0;
            m_tx = 0; m_rx = 0; m_since = 0; m_edges = 0; m_shifts = 0;
            m_q.delete();
        end else begin
            busy_old = m_busy;
            hv_old   = m_hold_v;
            tk  = m_busy && (m_since >= int'(cfg_div));
            fin = tk && (m_edges == 47);
            if (tk) begin
                e   = m_edges + 1;
                smp = cfg_cpha ? (e % 2 == 0) : (e % 2 == 1);
                if (smp) m_rx = {m_rx[22:0], miso};
                else if (e > 1) m_shifts++;
                m_edges = e;
                m_since = 0;
            end else if (m_busy) begin
                m_since++;
            end
            if (rx_rd && m_q.size() > 0) void'(m_q.pop_front());
            if (fin) begin
                if (m_q.size() < 2) m_q.push_back(m_rx);
                else m_ovr = 1;
                m_busy = 0;
            end
            if (!ss_old) m_berr = 1;
            if (hv_old && (!busy_old || fin)) begin
                m_tx = m_hold; m_shifts = 0; m_edges = 0; m_since = 0;
                m_busy = 1; m_hold_v = 0;
            end else if (tx_wr && !hv_old) begin
                m_hold_v = 1; m_hold = tx_data;
            end
        end
    end

    task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit act, e_txe, e_rxne;
        if (!rst && !done) begin
            act    = cfg_enable && !cfg_mode_sel && cfg_master;
            e_txe  = !m_hold_v;
            e_rxne = m_q.size() > 0;
            chk("R3 sck", {23'd0, sck}, {23'd0, cfg_cpol ^ (m_edges % 2 == 1)});
            chk("R4 mosi", {23'd0, mosi}, {23'd0, m_tx[23 - m_shifts]});
            chk("R5 tx_empty", {23'd0, stat_tx_empty}, {23'd0, e_txe});
            chk("R6 rx_nempty", {23'd0, stat_rx_nempty}, {23'd0, e_rxne});
            if (e_rxne) chk("R6 rx_data", rx_data, m_q[0]);
            chk("R7 rx_ovr", {23'd0, stat_rx_ovr}, {23'd0, m_ovr});
            chk("R8 berr", {23'd0, stat_berr}, {23'd0, m_berr});
            chk("R9 irq", {23'd0, irq}, {23'd0, act && ((m_berr && cfg_berr_ie) ||
                 (e_txe && cfg_txe_ie) || (e_rxne && cfg_rxne_ie))});
        end
    end

    // MISO source
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (miso_mode)
                0: miso = 1'b0;
                1: miso = 1'b1;
                2: miso = mosi;
                default: miso = lfsr[0];
            endcase
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [23:0] d);
        @(posedge clk); #1;
        tx_wr = 1; tx_data = d;
        @(posedge clk); #1;
        tx_wr = 0;
    endtask

    task automatic rd();
        @(posedge clk); #1;
        rx_rd = 1;
        @(posedge clk); #1;
        rx_rd = 0;
    endtask

    task automatic set_on(input logic pol, input logic pha, input logic [7:0] dv);
        cfg_enable = 0;
        cyc(2);
        cfg_cpol = pol; cfg_cpha = pha; cfg_div = dv;
        cfg_mode_sel = 0; cfg_master = 1; cfg_enable = 1;
        cyc(1);
    endtask

    initial begin
        cyc(3);
        // reset state
        chk("R1 reset tx_empty", {23'd0, stat_tx_empty}, 24'd1);
        chk("R1 reset rx_nempty", {23'd0, stat_rx_nempty}, 24'd0);
        chk("R1 reset sck", {23'd0, sck}, 24'd0);
        chk("R1 reset irq", {23'd0, irq}, 24'd0);
        rst = 0;
        cyc(2);

        // loopback, cpha=0
        miso_mode = 2;
        set_on(0, 0, 1);
        wr(24'hA5C3F0);
        cyc(110);
        chk("R4 loopback cpha0", rx_data, 24'hA5C3F0);
        chk("R6 word present", {23'd0, stat_rx_nempty}, 24'd1);
        rd();
        chk("R6 pop empties", {23'd0, stat_rx_nempty}, 24'd0);

        // loopback cpha=1 cpol=1, back-to-back plus dropped write
        set_on(1, 1, 0);
        cfg_txe_ie = 1; cfg_rxne_ie = 1;
        wr(24'h123456);
        wr(24'hFEDCBA);
        wr(24'h777777);
        cyc(120);
        chk("R4 loopback cpha1 first", rx_data, 24'h123456);
        rd();
        chk("R5 back-to-back second", rx_data, 24'hFEDCBA);
        rd();
        chk("R2 write while full dropped", {23'd0, stat_rx_nempty}, 24'd0);

        // overrun with constant ones
        miso_mode = 1;
        set_on(0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            wr(24'h00F00F + 24'(i));
            cyc(55);
        end
        chk("R7 overrun flag", {23'd0, stat_rx_ovr}, 24'd1);
        chk("R7 oldest kept", rx_data, 24'hFFFFFF);

        // disable mid-transfer
        wr(24'h135790);
        cyc(10);
        cfg_enable = 0;
        cyc(2);
        chk("R10 queue flushed", {23'd0, stat_rx_nempty}, 24'd0);
        chk("R10 overrun cleared", {23'd0, stat_rx_ovr}, 24'd0);
        chk("R10 sck idle", {23'd0, sck}, 24'd0);

        // random MISO
        miso_mode = 3;
        set_on(1, 0, 2);
        for (int i = 0; i < 4; i++) begin
            wr(24'h5A5A5A ^ 24'(i * 7919));
            cyc(150);
            rd();
        end

        // slave-select fault while active
        cfg_berr_ie = 1; cfg_txe_ie = 0; cfg_rxne_ie = 0;
        ss_n = 0; cyc(1); ss_n = 1;
        cyc(3);
        chk("R8 berr set", {23'd0, stat_berr}, 24'd1);
        chk("R9 irq from berr", {23'd0, irq}, 24'd1);

        // inactive: protocol select wrong
        cfg_mode_sel = 1;
        cyc(2);
        chk("R10 berr cleared", {23'd0, stat_berr}, 24'd0);
        ss_n = 0;
        wr(24'hABCDEF);
        cyc(60);
        ss_n = 1;
        chk("R1 write ignored", {23'd0, stat_tx_empty}, 24'd1);
        chk("R1 no berr inactive", {23'd0, stat_berr}, 24'd0);
        chk("R1 sck rests", {23'd0, sck}, {23'd0, cfg_cpol});
        chk("R1 no irq", {23'd0, irq}, 24'd0);
        cfg_mode_sel = 0; cfg_master = 0;
        wr(24'h111111);
        cyc(60);
        chk("R1 non-master ignored", {23'd0, stat_rx_nempty}, 24'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule